// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Stage

A single-clock pipeline stage that moves data words from an upstream channel to a downstream channel. Both channels use a four-phase request/acknowledge protocol: the sender raises a request with a word, the receiver raises an acknowledge, the sender drops the request, and the receiver drops the acknowledge. The stage acts as receiver on its input side and as sender on its output side.

A one-bit occupancy flag and a holding register keep one word between the two handshakes. The word is copied to a separate output register when the output request is raised. This lets the input side take the next word while the current one is still being presented downstream. Each channel performs its return-to-zero step on its own, without waiting for the other channel. When the stage is in reset, its input acknowledge is held high, so a sender that is already requesting is kept off until it lowers its request.

Top module: `hs_xfer_stage`

## Requirements
- R1: When the input request is high, the input acknowledge is low and the flag is empty, the stage captures `in_data_i` and the input acknowledge is high after the next rising clock edge.
- R2: When the input request is low and the input acknowledge is high, the input acknowledge is low after the next rising clock edge.
- R3: The output request rises only from a cycle in which both the output request and the output acknowledge were low and a word was held.
- R4: When the output request and the output acknowledge are both high, the output request is low after the next rising clock edge.
- R5: During reset the input acknowledge is 1 and the output request is 0. A sender that holds its request high through reset release gets no acceptance until it drops the request.
- R6: `out_data_o` does not change while the output request is high.
- R7: Words leave in the order they were accepted, with none lost and none repeated, whatever the sender and receiver delays are.
- R8: With the default occupancy reset value (`FULL_INIT` = 0, empty), the output request stays low after reset until a word has been accepted.
- R9: The stage transfers correctly when `DATA_W` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_req_i | input | 1 | Input channel request |
| in_data_i | input | DATA_W | Input channel data word |
| in_ack_o | output | 1 | Input channel acknowledge |
| out_req_o | output | 1 | Output channel request |
| out_data_o | output | DATA_W | Output channel data word |
| out_ack_i | input | 1 | Output channel acknowledge |

## Verification
The input-side and output-side events can happen in the same clock cycle. One case is the acceptance of a new word in the cycle where the output request returns to zero. Another is the raising of the output request in the cycle where the input acknowledge is cleared. Both are provoked by running the sender and the receiver with random delays that include zero, so these events line up many times over a long word stream. The result is judged by the scoreboard, which requires every word to arrive in order exactly once and the output word to stay constant while the output request is high. It is also judged by the per-channel return-to-zero properties.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    OCC_EMPTY = 1'b0,
    OCC_FULL  = 1'b1
  } occ_e;
endpackage

// File: rtl/hs_rx_side.sv
module hs_rx_side #(
  parameter int unsigned DATA_W = 37
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              full_i,
  output logic              ack_o,
  output logic              accept_o,
  output logic [DATA_W-1:0] hold_o
);
  logic              ack_q;
  logic [DATA_W-1:0] hold_q;

  assign accept_o = req_i & ~ack_q & ~full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b1;
      hold_q <= '0;
    end else begin
      // return-to-zero first, then the transfer event
      if (!req_i && ack_q) ack_q <= 1'b0;
      if (accept_o) begin
        ack_q  <= 1'b1;
        hold_q <= data_i;
      end
    end
  end

  assign ack_o  = ack_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/hs_tx_side.sv
module hs_tx_side #(
  parameter int unsigned DATA_W = 37
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              req_o,
  output logic              emit_o,
  output logic [DATA_W-1:0] data_o
);
  logic              req_q;
  logic [DATA_W-1:0] data_q;

  assign emit_o = ~req_q & ~ack_i & full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (req_q && ack_i) req_q <= 1'b0;
      if (emit_o) begin
        req_q  <= 1'b1;
        data_q <= hold_i;
      end
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;
endmodule

// File: rtl/hs_occ_flag.sv
module hs_occ_flag
  import hs_pkg::*;
#(
  parameter bit FULL_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_i,
  input  logic drain_i,
  output logic full_o
);
  localparam occ_e INIT_STATE = FULL_INIT ? OCC_FULL : OCC_EMPTY;
  occ_e occ_q;

  // fixed order, later write wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= INIT_STATE;
    end else begin
      if (fill_i)  occ_q <= OCC_FULL;
      if (drain_i) occ_q <= OCC_EMPTY;
    end
  end

  assign full_o = (occ_q == OCC_FULL);
endmodule

// File: rtl/hs_xfer_stage.sv
module hs_xfer_stage #(
  parameter int unsigned DATA_W    = 37,
  parameter bit          FULL_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_req_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ack_o,
  output logic              out_req_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ack_i
);
  logic              full;
  logic              accept;
  logic              emit;
  logic [DATA_W-1:0] hold;

  hs_rx_side #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (in_req_i),
    .data_i   (in_data_i),
    .full_i   (full),
    .ack_o    (in_ack_o),
    .accept_o (accept),
    .hold_o   (hold)
  );

  hs_occ_flag #(.FULL_INIT(FULL_INIT)) u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fill_i  (accept),
    .drain_i (emit),
    .full_o  (full)
  );

  hs_tx_side #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (out_ack_i),
    .full_i (full),
    .hold_i (hold),
    .req_o  (out_req_o),
    .emit_o (emit),
    .data_o (out_data_o)
  );
endmodule

// File: rtl/hs_xfer_stage_chk.sv
module hs_xfer_stage_chk #(
  parameter int unsigned DATA_W = 37
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_req_i,
  input logic              in_ack_o,
  input logic              out_req_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ack_i
);
  p_ack_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(in_req_i));

  p_in_rtz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_req_i && in_ack_o) |=> !in_ack_o);

  p_ack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_i && in_ack_o) |=> in_ack_o);

  p_req_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> $past(!out_ack_i));

  p_out_rtz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && out_ack_i) |=> !out_req_o);

  p_data_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && !out_ack_i) |=> $stable(out_data_o));
endmodule

bind hs_xfer_stage hs_xfer_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_req_i   (in_req_i),
  .in_ack_o   (in_ack_o),
  .out_req_o  (out_req_o),
  .out_data_o (out_data_o),
  .out_ack_i  (out_ack_i)
);

// File: tb/sim_hs_xfer_stage.sv
module sim_hs_xfer_stage;
  localparam int W      = 37;
  localparam int NWORDS = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic         in_req = 1'b0, out_ack = 1'b0, in_ack, out_req;
  logic [W-1:0] in_data = '0, out_data;

  logic         in_req1 = 1'b0, out_ack1 = 1'b0, in_ack1, out_req1;
  logic [0:0]   in_data1 = '0, out_data1;

  hs_xfer_stage #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_req_i(in_req), .in_data_i(in_data),
    .in_ack_o(in_ack), .out_req_o(out_req), .out_data_o(out_data), .out_ack_i(out_ack));

  hs_xfer_stage #(.DATA_W(1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .in_req_i(in_req1), .in_data_i(in_data1),
    .in_ack_o(in_ack1), .out_req_o(out_req1), .out_data_o(out_data1), .out_ack_i(out_ack1));

  int errors = 0, checks = 0, received = 0, received1 = 0;
  logic [W-1:0] sb_q[$];
  logic [0:0]   sb1_q[$];
  bit           rx_quiet = 1'b1;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic [W-1:0] w, input int dly);
    repeat (dly) @(negedge clk);
    sb_q.push_back(w);
    in_data = w;
    in_req  = 1'b1;
    do @(negedge clk); while (!in_ack);
    in_req = 1'b0;
    do @(negedge clk); while (in_ack);
  endtask

  // monitor / receiver for u0
  initial begin
    logic [W-1:0] seen, exp;
    forever begin
      @(negedge clk);
      if (out_req && !out_ack) begin
        seen = out_data;
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected word", seen, '0);
        end else begin
          exp = sb_q.pop_front();
          check(seen == exp, "R7 order/value", seen, exp);
        end
        received++;
        if (!rx_quiet) repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          check(out_data == seen && out_req, "R6 data stable", out_data, seen);
        end
        out_ack = 1'b1;
        do @(negedge clk); while (out_req);
        out_ack = 1'b0;
      end
    end
  end

  // receiver for u1, always acks at once
  initial begin
    logic [0:0] e1;
    forever begin
      @(negedge clk);
      if (out_req1 && !out_ack1) begin
        e1 = (sb1_q.size() != 0) ? sb1_q.pop_front() : 1'bx;
        check(out_data1 === e1, "R9 width-1 word", W'(out_data1), W'(e1));
        received1++;
        out_ack1 = 1'b1;
      end else if (!out_req1) begin
        out_ack1 = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    in_req  = 1'b1;
    in_data = W'('h5);
    repeat (3) @(negedge clk);
    check(in_ack == 1'b1, "R5 reset ack", W'(in_ack), 1);
    check(out_req == 1'b0, "R5 reset req", W'(out_req), 0);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(in_ack == 1'b1, "R5 hold-off ack", W'(in_ack), 1);
      check(out_req == 1'b0, "R8 no word after reset", W'(out_req), 0);
    end
    in_req = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R2 input rtz", W'(in_ack), 0);
    repeat (3) begin
      @(negedge clk);
      check(out_req == 1'b0, "R8 held-off word not taken", W'(out_req), 0);
    end

    // directed acceptance timing
    sb_q.push_back(W'('h1_2345_6789));
    in_data = W'('h1_2345_6789);
    in_req  = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b1, "R1 accept in one edge", W'(in_ack), 1);
    in_req = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R2 rtz after accept", W'(in_ack), 0);
    check(out_req == 1'b1, "R3 request after fill", W'(out_req), 1);
    repeat (6) @(negedge clk);
    check(out_req == 1'b0, "R4 output rtz", W'(out_req), 0);

    // random stream, zero delays included
    rx_quiet = 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      logic [W-1:0] w;
      w = {$urandom(), $urandom()};
      if (i % 17 == 0) w = '0;
      if (i % 19 == 0) w = '1;
      send(w, (i < 40) ? 0 : $urandom_range(0, 3));
    end
    repeat (40) @(negedge clk);
    check(received == NWORDS + 1, "R7 word count", W'(received), W'(NWORDS + 1));
    check(sb_q.size() == 0, "R7 none left", W'(sb_q.size()), 0);

    // width-1 instance
    for (int i = 0; i < 6; i++) begin
      logic [0:0] b;
      b = 1'((i == 1 || i == 4) ? 0 : 1);
      sb1_q.push_back(b);
      in_data1 = b;
      in_req1  = 1'b1;
      do @(negedge clk); while (!in_ack1);
      in_req1 = 1'b0;
      do @(negedge clk); while (in_ack1);
    end
    repeat (10) @(negedge clk);
    check(received1 == 6, "R9 width-1 count", W'(received1), 6);
    finish_run();
  end
endmodule